// File: doc/BRIEF.md
# Channel-Tagged Sample FIFO with Threshold Interrupt

This block buffers converted samples between an acquisition sequencer and a host bus. Each sample is 16 bits wide and travels with the number of the individual input channel that produced it. The sequencer pushes tagged samples through a valid/ready port. It can also ask for a flush, which throws away everything stored. The host side gets register-select strobes from an external address decoder and has three read strobes. A word read returns a whole sample and removes it from the FIFO. A low-byte read looks at the head sample without removing it. A high-byte read returns the upper half of the sample and removes it.

A 16-bit status word shows, in a single read, three things: the live fill count in bits 15:6, the channel tag of the sample at the head in bits 5:1, and the interrupt enable in bit 0. A write to the status word loads a new interrupt threshold from bits 15:6 and a new enable from bit 0. The interrupt output is a level. It stays high as long as the enable is set and the fill count is at or above the threshold.

Back-pressure rules for the push port: `in_ready` is high whenever the FIFO holds fewer than 512 entries. A sample is taken on a rising clock edge only when `in_valid` and `in_ready` are both high. If `in_valid` is high while `in_ready` is low, the sample is not taken; the sequencer may hold it or drop it. `flush_req` overrides everything: a push in the same cycle is lost.

Top module: `tagged_sample_fifo`

## Requirements
- R1: The FIFO holds 512 entries. When the count reaches 512, `full` is 1 and `in_ready` is 0. A sample offered with `in_valid` while full is not stored, and the count stays at 512.
- R2: Each accepted push adds one to the fill count. The count reads back in status bits 15:6 on the cycle after the push edge.
- R3: A word read (`rd_word`) loads the head sample into `rd_data` at the clock edge and removes that sample. Samples leave in the order they were pushed.
- R4: A low-byte read (`rd_lo`) loads `rd_data` with {8'h00, head[7:0]}. It does not remove the sample, and the count and head tag are left unchanged.
- R5: A high-byte read (`rd_hi`) loads `rd_data` with {8'h00, head[15:8]} and removes the head sample.
- R6: Status bits 5:1 show the channel tag of the head sample, which is an individual channel number. They read as 0 while the FIFO is empty.
- R7: A status write (`stat_wr`) loads the threshold from `stat_wdata[15:6]` and the enable from `stat_wdata[0]`. Status reads of bits 15:6 always show the fill count, never the threshold. After reset the threshold is 256 and the enable is 0.
- R8: `irq` is high, as a level, exactly when the enable is 1 and the fill count is at or above the threshold.
- R9: `flush_req` empties the FIFO on the next edge. A push in the same cycle is discarded.
- R10: Any read strobe while the FIFO is empty leaves `rd_data` unchanged and the count at 0.
- R11: Reset leaves the FIFO empty, the count at 0, `rd_data` at 0 and `irq` at 0. If more than one read strobe is high in a cycle, the priority is word, then high byte, then low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sequencer offers a sample |
| in_ready | output | 1 | FIFO can take a sample (not full) |
| in_data | input | 16 | Sample value |
| in_tag | input | 5 | Channel number of the sample |
| flush_req | input | 1 | Empty the FIFO |
| rd_word | input | 1 | 16-bit data read strobe (pops) |
| rd_lo | input | 1 | Low-byte read strobe (no pop) |
| rd_hi | input | 1 | High-byte read strobe (pops) |
| rd_data | output | 16 | Registered read result |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write value: threshold 15:6, enable 0 |
| stat_rdata | output | 16 | Count 15:6, head tag 5:1, enable 0 |
| irq | output | 1 | Level interrupt, active high |
| full | output | 1 | 512 entries held |
| empty | output | 1 | No entries held |

## Verification
The assertions check the following on every cycle:
- `in_ready` is low whenever `full` is high, and the count never exceeds the depth.
- The head tag is zero while the FIFO is empty.
- A flush leaves the FIFO empty.
- A lone low-byte read leaves the count alone.
- Reads while empty leave `rd_data` unchanged.
- `irq` is never high with the enable clear.
- The enable follows the last status write.

Only the bench scenarios can show the rest:
- Samples leave in push order.
- The byte halves of a sample come out correctly.
- `irq` rises and falls exactly at the programmed threshold.
- A threshold write does not disturb the count shown in the status word.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WORD = 2'd1,
    RD_LOW  = 2'd2,
    RD_HIGH = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] head_data,
  output logic [TAG_W-1:0]  head_tag,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam int AW  = $clog2(DEPTH);
  localparam int EW  = DATA_W + TAG_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  logic [EW-1:0] head_ent;

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // Write port: no reset on the storage array itself.
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= {wr_tag, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_ent  = mem[rd_ptr];
  assign head_data = head_ent[DATA_W-1:0];
  assign head_tag  = empty ? '0 : head_ent[EW-1:DATA_W];
endmodule

// File: rtl/tsf_read_port.sv
module tsf_read_port
  import tsf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_kind_e          kind,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pop
);
  localparam int HALF = DATA_W / 2;

  assign pop = !empty && (kind == RD_WORD || kind == RD_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (!empty) begin
      case (kind)
        RD_WORD: rd_data <= head_data;
        RD_LOW:  rd_data <= {{(DATA_W-HALF){1'b0}}, head_data[HALF-1:0]};
        RD_HIGH: rd_data <= {{HALF{1'b0}}, head_data[DATA_W-1:HALF]};
        default: rd_data <= rd_data;
      endcase
    end
  end
endmodule

// File: rtl/tsf_irq_ctrl.sv
module tsf_irq_ctrl #(
  parameter int CNT_W     = 10,
  parameter int THR_RESET = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_thr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] count,
  output logic             en,
  output logic             irq
);
  logic [CNT_W-1:0] thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr <= CNT_W'(THR_RESET);
      en  <= 1'b0;
    end else if (wr) begin
      thr <= wr_thr;
      en  <= wr_en;
    end
  end

  assign irq = en && (count >= thr);
endmodule

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 5,
  parameter int THR_RESET = DEPTH / 2,
  localparam int CNT_W    = $clog2(DEPTH) + 1,
  localparam int CNT_LSB  = TAG_W + 1,
  localparam int STAT_W   = CNT_LSB + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              flush_req,
  input  logic              rd_word,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq,
  output logic              full,
  output logic              empty
);
  rd_kind_e         kind;
  logic             pop;
  logic [DATA_W-1:0] head_data;
  logic [TAG_W-1:0]  head_tag;
  logic [CNT_W-1:0]  count;
  logic              irq_en;

  always_comb begin
    if (rd_word)    kind = RD_WORD;
    else if (rd_hi) kind = RD_HIGH;
    else if (rd_lo) kind = RD_LOW;
    else            kind = RD_NONE;
  end

  tsf_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_req),
    .push(in_valid), .pop(pop),
    .wr_data(in_data), .wr_tag(in_tag),
    .head_data(head_data), .head_tag(head_tag),
    .count(count), .full(full), .empty(empty)
  );

  tsf_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .kind(kind), .empty(empty),
    .head_data(head_data), .rd_data(rd_data), .pop(pop)
  );

  tsf_irq_ctrl #(.CNT_W(CNT_W), .THR_RESET(THR_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr(stat_wr),
    .wr_thr(stat_wdata[STAT_W-1:CNT_LSB]), .wr_en(stat_wdata[0]),
    .count(count), .en(irq_en), .irq(irq)
  );

  assign in_ready   = !full;
  assign stat_rdata = {count, head_tag, irq_en};
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int DEPTH     = 512,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 5,
  parameter int THR_RESET = DEPTH / 2,
  localparam int CNT_W    = $clog2(DEPTH) + 1,
  localparam int CNT_LSB  = TAG_W + 1,
  localparam int STAT_W   = CNT_LSB + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [TAG_W-1:0]  in_tag,
  input logic              flush_req,
  input logic              rd_word,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [DATA_W-1:0] rd_data,
  input logic              stat_wr,
  input logic [STAT_W-1:0] stat_wdata,
  input logic [STAT_W-1:0] stat_rdata,
  input logic              irq,
  input logic              full,
  input logic              empty
);
  logic [CNT_W-1:0] cnt;
  assign cnt = stat_rdata[STAT_W-1:CNT_LSB];

  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_empty_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> stat_rdata[TAG_W:1] == '0);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (empty && cnt == '0));
  assert_lo_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_word && !rd_hi && !in_valid && !flush_req) |=> $stable(cnt));
  assert_empty_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_word || rd_hi || rd_lo) && empty) |=> $stable(rd_data));
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_rdata[0]);
  assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> stat_rdata[0] == $past(stat_wdata[0]));
endmodule

bind tagged_sample_fifo tsf_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .THR_RESET(THR_RESET)
) u_chk (.*);

// File: tb/tagged_sample_fifo_test.sv
module tagged_sample_fifo_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;      // 0 push, 1 word read, 2 low byte, 3 high byte
    logic [15:0] d;
    logic [4:0]  tag;
    logic [15:0] exp_rd;
    logic [9:0]  exp_cnt;
    logic [4:0]  exp_tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h1234, 5'd3,  16'h0000, 10'd1, 5'd3},
    '{2'd0, 16'hABCD, 5'd7,  16'h0000, 10'd2, 5'd3},
    '{2'd2, 16'h0000, 5'd0,  16'h0034, 10'd2, 5'd3},
    '{2'd3, 16'h0000, 5'd0,  16'h0012, 10'd1, 5'd7},
    '{2'd1, 16'h0000, 5'd0,  16'hABCD, 10'd0, 5'd0},
    '{2'd1, 16'h0000, 5'd0,  16'hABCD, 10'd0, 5'd0},
    '{2'd0, 16'h8001, 5'd15, 16'hABCD, 10'd1, 5'd15},
    '{2'd0, 16'h00FF, 5'd12, 16'hABCD, 10'd2, 5'd15},
    '{2'd1, 16'h0000, 5'd0,  16'h8001, 10'd1, 5'd12},
    '{2'd3, 16'h0000, 5'd0,  16'h0000, 10'd0, 5'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data = '0;
  logic [4:0]  in_tag = '0;
  logic        flush_req = 1'b0, rd_word = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [15:0] rd_data;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] stat_rdata;
  logic        irq, full, empty;
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_sample_fifo uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    in_valid = 0; rd_word = 0; rd_lo = 0; rd_hi = 0;
    flush_req = 0; stat_wr = 0;
  endtask

  task automatic push(input logic [15:0] d, input logic [4:0] t);
    in_valid = 1; in_data = d; in_tag = t;
    cycle();
  endtask

  task automatic wr_stat(input logic [9:0] thr, input logic en);
    stat_wr = 1; stat_wdata = {thr, 5'd0, en};
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 empty", empty, 1);
    chk("R11 count", stat_rdata[15:6], 0);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 irq", irq, 0);
    chk("R6 empty tag", stat_rdata[5:1], 0);

    // Table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: begin in_valid = 1; in_data = VECS[i].d; in_tag = VECS[i].tag; end
        2'd1: rd_word = 1;
        2'd2: rd_lo = 1;
        default: rd_hi = 1;
      endcase
      cycle();
      if (VECS[i].op != 2'd0) chk("R3/R4/R5/R10 rd_data", rd_data, VECS[i].exp_rd);
      chk("R2 count", stat_rdata[15:6], VECS[i].exp_cnt);
      chk("R6 head tag", stat_rdata[5:1], VECS[i].exp_tag);
    end

    // R1 fill to full
    for (int i = 0; i < 512; i++) push(16'(i), 5'(i % 16));
    chk("R1 count", stat_rdata[15:6], 512);
    chk("R1 full", full, 1);
    chk("R1 in_ready", in_ready, 0);
    push(16'hDEAD, 5'd1);
    chk("R1 offered while full", stat_rdata[15:6], 512);
    chk("R8 irq disabled", irq, 0);
    wr_stat(10'd256, 1'b1);
    chk("R8 irq at full", irq, 1);
    chk("R7 count field not threshold", stat_rdata[15:6], 512);
    chk("R7 enable readback", stat_rdata[0], 1);
    rd_word = 1; cycle();
    chk("R3 order first", rd_data, 16'h0000);
    chk("R3 count dec", stat_rdata[15:6], 511);
    rd_word = 1; cycle();
    chk("R3 order second", rd_data, 16'h0001);
    chk("R6 tag after pops", stat_rdata[5:1], 2);

    // R9 flush beats push
    flush_req = 1; in_valid = 1; in_data = 16'h5555; in_tag = 5'd4;
    cycle();
    chk("R9 empty", empty, 1);
    chk("R9 count", stat_rdata[15:6], 0);
    chk("R8 irq after flush", irq, 0);

    // R8 programmable threshold
    wr_stat(10'd3, 1'b1);
    chk("R7 count after thr write", stat_rdata[15:6], 0);
    push(16'h0A0B, 5'd1);
    push(16'h0C0D, 5'd2);
    chk("R8 below threshold", irq, 0);
    push(16'h0E0F, 5'd3);
    chk("R8 at threshold", irq, 1);
    rd_lo = 1; cycle();
    chk("R4 low byte", rd_data, 16'h000B);
    chk("R4 no pop count", stat_rdata[15:6], 3);
    chk("R8 still high", irq, 1);
    rd_word = 1; cycle();
    chk("R8 below after pop", irq, 0);
    // R11 priority: word beats high/low
    rd_word = 1; rd_hi = 1; rd_lo = 1; cycle();
    chk("R11 priority word", rd_data, 16'h0C0D);
    wr_stat(10'd1, 1'b0);
    chk("R7 enable cleared", stat_rdata[0], 0);
    chk("R8 irq off when disabled", irq, 0);

    // R11 reset mid-run
    rst_n = 0; cycle(); rst_n = 1;
    chk("R11 reset count", stat_rdata[15:6], 0);
    chk("R11 reset rd_data", rd_data, 0);
    chk("R11 reset enable", stat_rdata[0], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule